// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single 16-bit counter channel programmed through a four-entry write-only register port. The control register selects one of four behaviours: a one-shot interval timer, a free-running periodic timer, a pulse-width-modulated output, or capture on one input pin. Capture can count edges, or record the counter value at each edge. An 8-bit prescaler divides the tick rate in the timer modes. The counter can run down toward zero or up from zero.

The channel drives four pulse outputs: a time-out interrupt, a match interrupt, a DMA trigger, and a PWM level. New interval or prescale values can take effect on the next clock or wait until the next time-out. Enabling the channel always restarts it from the programmed values. The capture pin passes through a two-flop synchroniser before its rising edges are detected.

Top module: `gp_timer`

## Requirements
- R1: Register map, written when `we_i` is high. Address 0 is control: bits 1:0 mode (1 one-shot, 2 periodic, 3 capture, 0 idle), bit 2 edge-time capture, bit 3 PWM, bit 4 count up, bit 5 match enable, bit 6 defer loads to time-out, bit 7 enable. Address 1 is the interval. Address 2 is the prescale (low 8 bits). Address 3 is the match value. After reset every output is 0.
- R2: In periodic down mode, the counter holds the interval one cycle after enable. `to_irq_o` pulses for one cycle every (interval+1)*(prescale+1) cycles.
- R3: In one-shot mode, exactly one time-out occurs. The channel then disables itself, and `count_o` rests at the interval value.
- R4: With the up bit set outside PWM, the counter is 0 one cycle after enable. A time-out occurs when the count equals the interval, giving a period of interval+1 ticks.
- R5: In one-shot or periodic mode with match enable set, `match_irq_o` pulses each time the count equals the match value. `dma_o` pulses on every time-out and on every such match.
- R6: With match enable clear, `match_irq_o` never pulses, and matches add no `dma_o` pulses.
- R7: In PWM mode (PWM bit set, edge-time bit clear, mode 1 or 2), the counter always runs down. `pwm_o` goes high at each reload and low on the tick where the count equals the match value. `match_irq_o` stays low.
- R8: With the defer bit clear, an interval write to a running down counter loads the counter on the next clock.
- R9: With the defer bit set and counting down, an interval write leaves the current count running. The new interval takes effect at the next time-out.
- R10: While counting up, the defer bit is ignored, and an interval write restarts the count from 0 on the next clock.
- R11: In edge-count capture, each synchronised rising edge of `cap_i` steps the counter. When the stepped count equals the match value, `to_irq_o` pulses and the channel disables itself.
- R12: In edge-time capture, each rising edge of `cap_i` copies the running count into `value_o` and pulses `to_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| cap_i | input | 1 | Capture pin, asynchronous |
| count_o | output | 16 | Current counter value |
| value_o | output | 16 | Start value after a load, or last captured count |
| to_irq_o | output | 1 | Time-out / capture event pulse |
| match_irq_o | output | 1 | Match interrupt pulse |
| dma_o | output | 1 | DMA trigger pulse |
| pwm_o | output | 1 | PWM level |

## Verification
The hardest case to reach is the deferred load. An interval write must leave the running count untouched and then change the reload period only after the pending time-out. To reach it, the bench starts a long down-count, writes a short interval a few cycles in, checks that the count is still high, waits past the old time-out, and then measures the new period by counting pulses. Edge-time capture has a fixed synchroniser latency. It is checked by placing two pin edges a known number of cycles apart and comparing the difference of the captured values, so the result does not depend on that latency.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_PERIODIC = 2'd2,
    MODE_CAPTURE  = 2'd3
  } mode_e;

  typedef struct packed {
    logic  en;
    logic  ld_at_to;
    logic  mie;
    logic  up;
    logic  pwm;
    logic  cap_time;
    mode_e mode;
  } ctrl_t;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_ILOAD = 2'd1;
  localparam logic [1:0] A_PLOAD = 2'd2;
  localparam logic [1:0] A_MATCH = 2'd3;

  function automatic logic is_pwm(ctrl_t c);
    return c.pwm && !c.cap_time && (c.mode == MODE_ONESHOT || c.mode == MODE_PERIODIC);
  endfunction

  function automatic logic is_up(ctrl_t c);
    return c.up && !is_pwm(c);
  endfunction
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          en_clr_i,
  input  logic          to_evt_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] ilr_o,
  output logic [PW-1:0] plr_o,
  output logic [CW-1:0] mtch_o,
  output logic          start_o,
  output logic          apply_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] ilr_q, mtch_q;
  logic [PW-1:0] plr_q;
  logic          start_q, pend_q;
  logic          ld_wr;

  assign ld_wr   = we_i && (addr_i == A_ILOAD || addr_i == A_PLOAD);
  // immediate loads apply next cycle; deferred ones ride on the time-out reload
  assign apply_o = pend_q && ctrl_q.en && (!ctrl_q.ld_at_to || is_up(ctrl_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ilr_q   <= '0;
      plr_q   <= '0;
      mtch_q  <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (we_i && addr_i == A_CTRL) begin
        ctrl_q  <= ctrl_t'(wdata_i[7:0]);
        start_q <= wdata_i[7] && !ctrl_q.en;
      end else if (en_clr_i) begin
        ctrl_q.en <= 1'b0;
      end
      if (we_i && addr_i == A_ILOAD) ilr_q  <= wdata_i;
      if (we_i && addr_i == A_PLOAD) plr_q  <= wdata_i[PW-1:0];
      if (we_i && addr_i == A_MATCH) mtch_q <= wdata_i;
      if (ld_wr)                                   pend_q <= 1'b1;
      else if (start_q || apply_o || to_evt_i)     pend_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign ilr_o   = ilr_q;
  assign plr_o   = plr_q;
  assign mtch_o  = mtch_q;
  assign start_o = start_q;
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [PW-1:0] plr_i,
  output logic          tick_o
);
  logic [PW-1:0] psc_q;

  assign tick_o = run_i && (psc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (load_i) psc_q <= plr_i;
    else if (run_i)  psc_q <= (psc_q == '0) ? plr_i : psc_q - 1'b1;
  end
endmodule

// File: rtl/gpt_capsync.sv
module gpt_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], cap_i};
  end

  assign rise_o = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [CW-1:0] ilr_i,
  input  logic [CW-1:0] mtch_i,
  input  logic          load_i,
  input  logic          tick_i,
  input  logic          rise_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] val_o,
  output logic          to_evt_o,
  output logic          en_clr_o,
  output logic          to_o,
  output logic          match_o,
  output logic          dma_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q, cnt_n, val_q, val_n, start_val, step;
  logic          pwm_q, pwm_n, to_q, match_q, dma_q, match_evt;
  logic          pwm_m, up_m, timer_m, cap_m, at_end;

  assign pwm_m     = is_pwm(ctrl_i);
  assign up_m      = is_up(ctrl_i);
  assign timer_m   = ctrl_i.mode == MODE_ONESHOT || ctrl_i.mode == MODE_PERIODIC;
  assign cap_m     = ctrl_i.mode == MODE_CAPTURE;
  assign start_val = up_m ? '0 : ilr_i;
  assign at_end    = up_m ? (cnt_q == ilr_i) : (cnt_q == '0);
  assign step      = up_m ? cnt_q + 1'b1 : cnt_q - 1'b1;

  always_comb begin
    cnt_n     = cnt_q;
    val_n     = val_q;
    pwm_n     = pwm_m ? pwm_q : 1'b0;
    to_evt_o  = 1'b0;
    match_evt = 1'b0;
    en_clr_o  = 1'b0;
    if (ctrl_i.en) begin
      if (load_i) begin
        cnt_n = start_val;
        val_n = start_val;
        pwm_n = pwm_m;
      end else if (timer_m && tick_i) begin
        if (cnt_q == mtch_i && !pwm_m && ctrl_i.mie) match_evt = 1'b1;
        if (at_end) begin
          to_evt_o = 1'b1;
          cnt_n    = start_val;
          pwm_n    = pwm_m;
          if (ctrl_i.mode == MODE_ONESHOT && !pwm_m) en_clr_o = 1'b1;
        end else begin
          cnt_n = step;
          if (pwm_m && cnt_q == mtch_i) pwm_n = 1'b0;
        end
      end else if (cap_m && !ctrl_i.cap_time) begin
        if (rise_i) begin
          cnt_n = step;
          if (step == mtch_i) begin
            to_evt_o = 1'b1;
            en_clr_o = 1'b1;
          end
        end
      end else if (cap_m) begin
        if (tick_i) cnt_n = at_end ? start_val : step;
        if (rise_i) begin
          val_n    = cnt_q;
          to_evt_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      val_q   <= '0;
      pwm_q   <= 1'b0;
      to_q    <= 1'b0;
      match_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      val_q   <= val_n;
      pwm_q   <= pwm_n;
      to_q    <= to_evt_o;
      match_q <= match_evt;
      dma_q   <= to_evt_o || match_evt;
    end
  end

  assign cnt_o   = cnt_q;
  assign val_o   = val_q;
  assign pwm_o   = pwm_q;
  assign to_o    = to_q;
  assign match_o = match_q;
  assign dma_o   = dma_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          cap_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] value_o,
  output logic          to_irq_o,
  output logic          match_irq_o,
  output logic          dma_o,
  output logic          pwm_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] ilr, mtch;
  logic [PW-1:0] plr;
  logic          start_q, apply, load, tick, rise, to_evt, en_clr;

  assign load = start_q || apply;

  gpt_regs #(.CW(CW), .PW(PW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .en_clr_i(en_clr), .to_evt_i(to_evt),
    .ctrl_o(ctrl), .ilr_o(ilr), .plr_o(plr), .mtch_o(mtch),
    .start_o(start_q), .apply_o(apply)
  );

  gpt_prescale #(.PW(PW)) u_psc (
    .clk_i, .rst_ni, .run_i(ctrl.en && !load), .load_i(load),
    .plr_i(plr), .tick_o(tick)
  );

  gpt_capsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cap_i, .rise_o(rise)
  );

  gpt_core #(.CW(CW)) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .ilr_i(ilr), .mtch_i(mtch),
    .load_i(load), .tick_i(tick), .rise_i(rise),
    .cnt_o(count_o), .val_o(value_o), .to_evt_o(to_evt), .en_clr_o(en_clr),
    .to_o(to_irq_o), .match_o(match_irq_o), .dma_o(dma_o), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
  import gpt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input ctrl_t         ctrl_i,
  input logic          start_i,
  input logic          load_i,
  input logic          we_i,
  input logic [CW-1:0] count_i,
  input logic          to_i,
  input logic          match_i,
  input logic          dma_i,
  input logic          pwm_i
);
  AST_MATCH_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> $past(ctrl_i.mie)); // R6
  AST_NO_MATCH_IN_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> !$past(is_pwm(ctrl_i))); // R7
  AST_DMA_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_i || match_i) |-> dma_i); // R5
  AST_PWM_RISE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_i) |-> (to_i || $past(load_i))); // R7
  AST_UP_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && is_up(ctrl_i)) |-> count_i == '0); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_i && $past(ctrl_i.en && ctrl_i.mode == MODE_ONESHOT && !is_pwm(ctrl_i) && !we_i))
    |-> !ctrl_i.en); // R3
endmodule

bind gp_timer gp_timer_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl), .start_i(start_q), .load_i(load),
  .we_i(we_i), .count_i(count_o), .to_i(to_irq_o), .match_i(match_irq_o),
  .dma_i(dma_o), .pwm_i(pwm_o)
);

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        cap = 1'b0;
  logic [15:0] count, value;
  logic        to_irq, match_irq, dma, pwm;

  int checks = 0, errors = 0;
  int n_to, n_match, n_dma, n_hi;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .cap_i(cap), .count_o(count), .value_o(value), .to_irq_o(to_irq),
    .match_irq_o(match_irq), .dma_o(dma), .pwm_o(pwm)
  );

  function automatic logic [15:0] cw(input int mode, input bit ct, input bit pw,
                                     input bit up, input bit mie, input bit dfr, input bit en);
    return {8'h00, en, dfr, mie, up, pw, ct, mode[1:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic zero();
    n_to = 0; n_match = 0; n_dma = 0; n_hi = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_to += int'(to_irq); n_match += int'(match_irq);
      n_dma += int'(dma); n_hi += int'(pwm);
    end
  endtask

  task automatic setup(input int il, input int pl, input int mt);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'(il)); wr(2'd2, 16'(pl)); wr(2'd3, 16'(mt));
  endtask

  task automatic t_reset();
    check("R1 count", count, 0); check("R1 value", value, 0);
    check("R1 irq", {to_irq, match_irq, dma, pwm}, 0);
  endtask

  task automatic t_periodic();
    setup(4, 0, 100);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0, 1));
    run(1); check("R2 start at interval", count, 4);
    run(10); zero(); run(50); check("R2 period 5", n_to, 10);
    setup(3, 1, 100);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0, 1));
    run(12); zero(); run(40); check("R2 prescaled period 8", n_to, 5);
  endtask

  task automatic t_oneshot();
    setup(3, 0, 100);
    wr(2'd0, cw(1, 0, 0, 0, 0, 0, 1));
    zero(); run(30);
    check("R3 single time-out", n_to, 1);
    check("R3 rests at interval", count, 3);
  endtask

  task automatic t_up();
    setup(5, 0, 100);
    wr(2'd0, cw(2, 0, 0, 1, 0, 0, 1));
    run(1); check("R4 up starts at 0", count, 0);
    run(10); zero(); run(60); check("R4 up period 6", n_to, 10);
  endtask

  task automatic t_match();
    setup(7, 0, 2);
    wr(2'd0, cw(2, 0, 0, 0, 1, 0, 1));
    run(10); zero(); run(80);
    check("R5 match pulses", n_match, 10);
    check("R5 dma pulses", n_dma, 20);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0, 1));
    run(10); zero(); run(80);
    check("R6 match suppressed", n_match, 0);
    check("R6 dma time-out only", n_dma, 10);
  endtask

  task automatic t_pwm();
    setup(9, 0, 3);
    wr(2'd0, cw(2, 0, 1, 1, 1, 0, 1));
    run(20); zero(); run(100);
    check("R7 pwm high cycles", n_hi, 70);
    check("R7 no match irq", n_match, 0);
    check("R7 reload rate", n_to, 10);
  endtask

  task automatic t_loads();
    setup(200, 0, 1000);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0, 1));
    run(5); wr(2'd1, 16'd20);
    run(1); check("R8 immediate load", count, 20);
    setup(200, 0, 1000);
    wr(2'd0, cw(2, 0, 0, 0, 0, 1, 1));
    run(5); wr(2'd1, 16'd20);
    run(1); check("R9 count undisturbed", int'(count > 16'd100), 1);
    run(220); zero(); run(84); check("R9 new period after time-out", n_to, 4);
    setup(200, 0, 1000);
    wr(2'd0, cw(2, 0, 0, 1, 0, 1, 1));
    run(10); wr(2'd1, 16'd20);
    run(1); check("R10 up restarts at 0", count, 0);
  endtask

  task automatic t_edge_count();
    setup(10, 0, 7);
    wr(2'd0, cw(3, 0, 0, 0, 0, 0, 1));
    zero();
    for (int k = 0; k < 5; k++) begin
      cap = 1'b1; run(3); cap = 1'b0; run(3);
    end
    run(4);
    check("R11 one event", n_to, 1);
    check("R11 stopped at match", count, 7);
  endtask

  task automatic t_edge_time();
    int v1, v2;
    setup(1000, 0, 5000);
    wr(2'd0, cw(3, 1, 0, 0, 0, 0, 1));
    zero(); run(5);
    cap = 1'b1; run(10); v1 = int'(value);
    cap = 1'b0; run(10);
    cap = 1'b1; run(10); v2 = int'(value);
    cap = 1'b0; run(5);
    check("R12 capture spacing", v1 - v2, 20);
    check("R12 events", n_to, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_oneshot();
    t_up();
    t_match();
    t_pwm();
    t_loads();
    t_edge_count();
    t_edge_time();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule